// File: doc/BRIEF.md
# DS3 Transmit Overhead Error Inserter

This block sits in the serial transmit path of a DS3 M-frame, one bit per clock. It follows each bit's place in the frame, starting from a frame-start strobe. It leaves payload bits alone and rewrites only the overhead bits. It can do four things to those bits, each under register control:

- Replace the parity bits with a supplied parity value, either as given or inverted.
- XOR the three multiframe-alignment bits with a 3-bit mask.
- XOR the 28 framing bits with a 28-bit mask.
- Fill the three far-end block error bits, either with a value derived from the local receiver's parity status or with a value written by software.

Test equipment uses it to send deliberately damaged frames to the far end. The parity calculation, payload mapping, line coding and receive framing are outside this block. A byte-wide register port gives write and read access to the control and mask registers.

Frame geometry is fixed. A frame has 7 subframes. Each subframe has 8 blocks. Each block is one overhead bit followed by `PAYLOAD_BITS` payload bits (84 in a real DS3 stream).

Within a subframe, the overhead bits come in the block order X/P/M, F1, C1, F2, C2, F3, C3, F4. The first overhead bit of subframes 1 to 7 is X, X, P, P, M, M, M. The far-end block error bits are the three C-bits of subframe 4.

Top module: `ds3_oh_err_inserter`

## Requirements
- R1: A bit presented with `in_valid` and `frame_start` both high is the first X-bit (subframe 1, block 1, overhead). The position advances by one for each valid bit. After the last bit of subframe 7 it wraps to the first X-bit even without a strobe. A `frame_start` without `in_valid` has no effect.
- R2: `out_valid` equals `in_valid` delayed by one clock. `out_bit` carries the processed version of the bit that was presented one clock earlier.
- R3: Payload bits, both X-bits, and the C-bits outside subframe 4 leave the block unchanged.
- R4: The two P-bit positions (subframes 3 and 4, block 1) carry `p_calc` when control bit 3 is 0, and carry its inverse when control bit 3 is 1.
- R5: The M-bits of subframes 5, 6 and 7 are XORed with control bits 2, 1 and 0 respectively.
- R6: The framing bit Fk of subframe s (s = 1..7, k = 1..4) is XORed with mask bit 27 − (4·(s−1) + (k−1)). Mask bits 27..24 are held in bits 3:0 of register 0x36. Mask bits 23..16, 15..8 and 7..0 are held in registers 0x37, 0x38 and 0x39.
- R7: When control bit 4 is 0, the three C-bits of subframe 4 carry 3'b111 if the most recent `rx_status_strobe` reported neither `rx_p_err` nor `rx_cp_err`, and carry 3'b000 if it reported either. After reset the status is treated as error-free.
- R8: When control bit 4 is 1, the three C-bits of subframe 4 carry control bits 7, 6 and 5, in transmit order. The receive status has no effect.
- R9: Register 0x35 reads back all 8 bits as written. Register 0x36 reads bits 7:4 as zero. Writes to addresses other than 0x35..0x39 change no register. Reads from any other address return zero.
- R10: After reset, every register reads zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks the current valid bit as the first X-bit |
| in_valid | input | 1 | Input bit is valid |
| in_bit | input | 1 | Serial input bit |
| p_calc | input | 1 | Parity value to place in the P-bit positions |
| rx_status_strobe | input | 1 | Latches the receive parity status |
| rx_p_err | input | 1 | Receiver saw a P-bit error in its latest frame |
| rx_cp_err | input | 1 | Receiver saw a CP-bit error in its latest frame |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| out_valid | output | 1 | Output bit is valid |
| out_bit | output | 1 | Serial output bit |

## Verification
The bench builds the block with `PAYLOAD_BITS` set to 4. This shrinks a frame to 280 bits while keeping the full overhead order. As a result, one run covers several frame wraps, a mid-frame restart, stretches with gaps in `in_valid`, and every combination of the FEBE sources.

A behavioural position model predicts every output bit from the requirement formulas. It is compared on each clock.

// File: rtl/ds3_oh_err_inserter.sv
module ds3_oh_err_inserter #(
  parameter int PAYLOAD_BITS = 84
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       p_calc,
  input  logic       rx_status_strobe,
  input  logic       rx_p_err,
  input  logic       rx_cp_err,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       out_valid,
  output logic       out_bit
);
  localparam int BLK_LEN = PAYLOAD_BITS + 1;
  localparam int BW      = $clog2(BLK_LEN + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BLK_LEN - 1);

  logic [BW-1:0] bit_q, bit_c;
  logic [2:0]    blk_q, blk_c, sub_q, sub_c;
  logic [7:0]    ctrl_q;
  logic [27:0]   fmask_q;
  logic          err_q;
  logic          oh, tx;
  logic [2:0]    febe;
  logic [4:0]    fidx;

  // Position of the current bit; a frame strobe forces the first X-bit (R1)
  assign bit_c = frame_start ? '0 : bit_q;
  assign blk_c = frame_start ? '0 : blk_q;
  assign sub_c = frame_start ? '0 : sub_q;
  assign oh    = (bit_c == '0);
  assign fidx  = 5'd27 - ({sub_c, 2'b00} + {3'b000, blk_c[2:1]});
  assign febe  = ctrl_q[4] ? ctrl_q[7:5] : (err_q ? 3'b000 : 3'b111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= '0;
      blk_q <= '0;
      sub_q <= '0;
    end else if (in_valid) begin
      if (bit_c == BIT_LAST) begin
        bit_q <= '0;
        if (blk_c == 3'd7) begin
          blk_q <= '0;
          sub_q <= (sub_c == 3'd6) ? 3'd0 : sub_c + 3'd1;
        end else begin
          blk_q <= blk_c + 3'd1;
          sub_q <= sub_c;
        end
      end else begin
        bit_q <= bit_c + BW'(1);
        blk_q <= blk_c;
        sub_q <= sub_c;
      end
    end
  end

  always_comb begin
    tx = in_bit;
    if (oh) begin
      if (blk_c == 3'd0) begin
        case (sub_c)
          3'd2, 3'd3: tx = p_calc ^ ctrl_q[3];
          3'd4:       tx = in_bit ^ ctrl_q[2];
          3'd5:       tx = in_bit ^ ctrl_q[1];
          3'd6:       tx = in_bit ^ ctrl_q[0];
          default:    tx = in_bit;
        endcase
      end else if (blk_c[0]) begin
        tx = in_bit ^ fmask_q[fidx];
      end else if (sub_c == 3'd3) begin
        case (blk_c[2:1])
          2'd1:    tx = febe[2];
          2'd2:    tx = febe[1];
          default: tx = febe[0];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_bit   <= in_valid ? tx : 1'b0;
    end
  end

  // Register file and receive status latch (R9, R10)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fmask_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rx_status_strobe) err_q <= rx_p_err | rx_cp_err;
      if (reg_wr) begin
        case (reg_addr)
          8'h35: ctrl_q          <= reg_wdata;
          8'h36: fmask_q[27:24]  <= reg_wdata[3:0];
          8'h37: fmask_q[23:16]  <= reg_wdata;
          8'h38: fmask_q[15:8]   <= reg_wdata;
          8'h39: fmask_q[7:0]    <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      8'h35:   reg_rdata = ctrl_q;
      8'h36:   reg_rdata = {4'h0, fmask_q[27:24]};
      8'h37:   reg_rdata = fmask_q[23:16];
      8'h38:   reg_rdata = fmask_q[15:8];
      8'h39:   reg_rdata = fmask_q[7:0];
      default: reg_rdata = 8'h00;
    endcase
  end

  assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q <= BIT_LAST) && (sub_q <= 3'd6));

  assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  assert_payload_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !oh) |=> out_bit == $past(in_bit));

  assert_p_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oh && blk_c == 3'd0 && (sub_c == 3'd2 || sub_c == 3'd3))
      |=> out_bit == ($past(p_calc) ^ $past(ctrl_q[3])));

  assert_m_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oh && blk_c == 3'd0 && sub_c >= 3'd4 && ctrl_q[2:0] == 3'd0)
      |=> out_bit == $past(in_bit));

  assert_f_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oh && blk_c[0] && fmask_q == '0) |=> out_bit == $past(in_bit));

  assert_febe_gen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oh && sub_c == 3'd3 && blk_c != 3'd0 && !blk_c[0] && !ctrl_q[4])
      |=> out_bit == !$past(err_q));
endmodule

// File: tb/ds3_oh_err_inserter_tb_top.sv
module ds3_oh_err_inserter_tb_top;
  localparam int PB    = 4;
  localparam int BLK   = PB + 1;
  localparam int FRAME = BLK * 56;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, in_valid = 0, in_bit = 0, p_calc = 0;
  logic rx_status_strobe = 0, rx_p_err = 0, rx_cp_err = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic out_valid, out_bit;

  ds3_oh_err_inserter #(.PAYLOAD_BITS(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .in_bit(in_bit), .p_calc(p_calc), .rx_status_strobe(rx_status_strobe),
    .rx_p_err(rx_p_err), .rx_cp_err(rx_cp_err), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_valid(out_valid), .out_bit(out_bit));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc_cnt = 0, m_pos = 0;
  bit done = 0;
  logic [7:0]  m_ctrl = 0;
  logic [27:0] m_fm = 0;
  logic m_err = 0, e_valid = 0, e_bit = 0;
  string e_tag = "R2";

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      done = 1; n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: actual %0d cycles, expected fewer", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic mirror(input logic [7:0] a, input int i);
    case (a)
      8'h35: return m_ctrl[i];
      8'h36: return (i < 4) ? m_fm[24+i] : 1'b0;
      8'h37: return m_fm[16+i];
      8'h38: return m_fm[8+i];
      8'h39: return m_fm[i];
      default: return 1'b0;
    endcase
  endfunction

  // Behavioural prediction of one output bit from its frame position
  function automatic void predict(input logic b, input logic p);
    int off = m_pos % BLK;
    int blk = (m_pos / BLK) % 8;
    int sub = m_pos / (BLK * 8);
    logic [2:0] fe = m_ctrl[4] ? m_ctrl[7:5] : (m_err ? 3'b000 : 3'b111);
    e_bit = b; e_tag = $sformatf("R3 pos %0d", m_pos);
    if (off == 0) begin
      if (blk == 0 && (sub == 2 || sub == 3)) begin
        e_bit = p ^ m_ctrl[3]; e_tag = $sformatf("R4 pos %0d", m_pos);
      end else if (blk == 0 && sub >= 4) begin
        e_bit = b ^ m_ctrl[6-sub]; e_tag = $sformatf("R5 pos %0d", m_pos);
      end else if (blk % 2 == 1) begin
        e_bit = b ^ m_fm[27 - (sub*4 + blk/2)]; e_tag = $sformatf("R6 pos %0d", m_pos);
      end else if (blk != 0 && sub == 3) begin
        e_bit = fe[3 - blk/2];
        e_tag = $sformatf("%s pos %0d", m_ctrl[4] ? "R8" : "R7", m_pos);
      end
    end
  endfunction

  task automatic check_out();
    n_cmp++;
    if (out_valid !== e_valid) begin
      n_bad++;
      $display("FAIL R2 out_valid: actual %b expected %b", out_valid, e_valid);
    end else if (e_valid && out_bit !== e_bit) begin
      n_bad++;
      $display("FAIL %s out_bit: actual %b expected %b", e_tag, out_bit, e_bit);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; frame_start = 0; reg_wr = 0; rx_status_strobe = 0;
  endtask

  task automatic cyc(input logic v, input logic b, input logic fs, input logic p);
    @(negedge clk); check_out(); idle_inputs();
    in_valid = v; in_bit = b; frame_start = fs; p_calc = p;
    e_valid = v;
    if (v) begin
      if (fs) m_pos = 0;
      predict(b, p);
      m_pos = (m_pos + 1) % FRAME;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); check_out(); idle_inputs();
    reg_wr = 1; reg_addr = a; reg_wdata = d; e_valid = 0;
    case (a)
      8'h35: m_ctrl = d;
      8'h36: m_fm[27:24] = d[3:0];
      8'h37: m_fm[23:16] = d;
      8'h38: m_fm[15:8] = d;
      8'h39: m_fm[7:0] = d;
      default: ;
    endcase
  endtask

  task automatic strobe(input logic pe, input logic ce);
    @(negedge clk); check_out(); idle_inputs();
    rx_status_strobe = 1; rx_p_err = pe; rx_cp_err = ce; e_valid = 0;
    m_err = pe | ce;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    logic [7:0] ex;
    @(negedge clk); check_out(); idle_inputs();
    reg_addr = a; e_valid = 0;
    #1;
    for (int i = 0; i < 8; i++) ex[i] = mirror(a, i);
    n_cmp++;
    if (reg_rdata !== ex) begin
      n_bad++;
      $display("FAIL %s read 0x%0h: actual %h expected %h", tag, a, reg_rdata, ex);
    end
  endtask

  task automatic run(input int nbits, input bit fs_first, input bit gaps);
    bit first = fs_first;
    int sent = 0;
    while (sent < nbits) begin
      logic v = gaps ? (($urandom % 4) != 0) : 1'b1;
      cyc(v, 1'($urandom), v & first, 1'($urandom));
      if (v) begin first = 0; sent++; end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_out();  // R10: out_valid low in reset
    rst_n = 1;
    rd(8'h35, "R10"); rd(8'h36, "R10"); rd(8'h37, "R10");
    rd(8'h38, "R10"); rd(8'h39, "R10");
    run(2 * FRAME, 1, 0);               // R1 wrap, R3, R4 plain, R7 all ones
    cyc(0, 1, 1, 0);                    // R1 strobe without valid ignored
    run(FRAME, 0, 0);
    wr(8'h35, 8'b000_0_1_101);          // R4 invert, R5 mask
    wr(8'h36, 8'hFF); wr(8'h37, 8'hA5); wr(8'h38, 8'h3C); wr(8'h39, 8'h81);
    rd(8'h36, "R9"); rd(8'h35, "R9"); rd(8'h37, "R9");
    wr(8'h40, 8'hFF); wr(8'h34, 8'hFF); // R9 unmapped writes
    rd(8'h40, "R9"); rd(8'h34, "R9"); rd(8'h38, "R9"); rd(8'h39, "R9");
    run(FRAME, 1, 0);                   // R6 masks applied
    strobe(1, 0); run(FRAME, 1, 0);     // R7 P error -> 000
    strobe(0, 1); run(FRAME, 1, 1);     // R7 CP error, R2 gaps
    strobe(0, 0); run(FRAME / 2 + 7, 1, 0);
    run(FRAME + 20, 1, 1);              // R1 restart mid-frame
    wr(8'h35, 8'b110_1_0_010); strobe(1, 1);
    run(FRAME, 1, 0);                   // R8 user FEBE 110
    wr(8'h35, 8'b011_1_1_000); strobe(0, 0);
    run(FRAME, 1, 1);                   // R8 user FEBE 011
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule